// File: doc/BRIEF.md
# Threshold Register Program and Readback Sequencer

This block holds the two 12-bit thresholds that a FIFO's almost-empty and almost-full flag logic compare against. Software or a host controller programs them over the FIFO's ordinary data path. An active-low load-select input steers a write-clock edge to the thresholds instead of to the buffer array. It likewise steers a read-clock edge to a readback register instead of to a buffer read.

No address is supplied. A one-bit pointer in the write domain alternates between the empty threshold and the full threshold on each qualified write edge. A separate pointer in the read domain alternates the same way on each qualified readback edge. Releasing load-select does not move either pointer, so a host may program one threshold, do normal traffic, and program the other later. Reset returns both pointers to the empty position and loads a default that depends on the FIFO depth: 0x01F up to 256 words, 0x03F up to 512, and 0x07F above that. Threshold bits that a smaller depth does not use are expected to be written as zero by the host. The block stores whatever it is given.

Top module: `thr_prog_seq`

## Requirements
- R1: While `rst_n` is low, `ae_thresh` and `af_thresh` equal the depth default (0x07F for the default DEPTH of 1024), `rd_dout` is zero, and both sequence pointers select the empty threshold.
- R2: With `load_n`=0 and `wr_en_n`=0, each rising `wr_clk` edge writes `wr_din` into the threshold the write pointer selects and then flips the pointer: empty first, then full, then empty again.
- R3: With `load_n`=1 and `wr_en_n`=0, `buf_wr` is 1 and neither threshold changes.
- R4: With `load_n`=0 and `wr_en_n`=1, neither threshold changes, the write pointer does not move, and `buf_wr` is 0.
- R5: The write pointer keeps its position across any cycles with `load_n`=1, so the next threshold write continues the alternation.
- R6: With `load_n`=0 and `rd_en_n`=0, each rising `rd_clk` edge loads `rd_dout` with the threshold the read pointer selects, empty first and full next, in bits 11:0, with bits 17:12 zero, and then flips the read pointer.
- R7: When `rd_en_n`=1 or `load_n`=1, `rd_dout` holds its value on a `rd_clk` edge; `buf_rd` is 1 exactly when `load_n`=1 and `rd_en_n`=0.
- R8: The read pointer and write pointer move independently, and a reset in mid-sequence returns both to the empty position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| load_n | input | 1 | Active-low load-select: steers edges to the thresholds |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| wr_din | input | 12 | Low bits of the shared data input, threshold write value |
| rd_dout | output | 18 | Readback register, threshold in low 12 bits |
| ae_thresh | output | 12 | Current almost-empty threshold |
| af_thresh | output | 12 | Current almost-full threshold |
| buf_wr | output | 1 | Write strobe steered to the buffer array |
| buf_rd | output | 1 | Read strobe steered to the buffer array |

## Verification
The bench programs only the empty threshold, runs normal writes and idle cycles, then programs again. A design that resets its pointer on load release would overwrite the empty value a second time instead of the full one. It checks that enable-high cycles with load-select low move nothing, which catches a pointer that advances on load-select alone. It resets in mid-sequence with both pointers on the full position; a design that left either pointer set would steer the next access to the wrong threshold. Random mixed traffic on both clocks is compared every cycle against a behavioural model, exposing swapped readback order or a readback that fails to hold.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    function automatic int unsigned depth_default(int unsigned depth);
        if (depth <= 256)
            return 32'h01F;
        else if (depth <= 512)
            return 32'h03F;
        else
            return 32'h07F;
    endfunction

    function automatic ofs_sel_e sel_next(ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/thr_steer.sv
module thr_steer (
    input  logic load_n,
    input  logic wr_en_n,
    input  logic rd_en_n,
    output logic prog_we,
    output logic prog_re,
    output logic buf_we,
    output logic buf_re
);

    always_comb begin
        prog_we = ~load_n & ~wr_en_n;
        prog_re = ~load_n & ~rd_en_n;
        buf_we  =  load_n & ~wr_en_n;
        buf_re  =  load_n & ~rd_en_n;
    end

    always_comb begin
        assert_steer_excl_R3: assert (!(prog_we && buf_we));
        assert_steer_excl_R7: assert (!(prog_re && buf_re));
    end

endmodule

// File: rtl/thr_wr_bank.sv
module thr_wr_bank
    import thr_pkg::*;
#(
    parameter int unsigned      OFS_W   = 12,
    parameter logic [OFS_W-1:0] RST_OFS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);

    typedef struct packed {
        ofs_sel_e         sel;
        logic [OFS_W-1:0] ae;
        logic [OFS_W-1:0] af;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prog_we) begin
            if (st_q.sel == SEL_EMPTY)
                st_d.ae = wdata;
            else
                st_d.af = wdata;
            st_d.sel = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= SEL_EMPTY;
            st_q.ae  <= RST_OFS;
            st_q.af  <= RST_OFS;
        end else begin
            st_q <= st_d;
        end
    end

    assign ae_q = st_q.ae;
    assign af_q = st_q.af;

    assert_wsel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> (st_q.sel != $past(st_q.sel)));

    assert_wsel_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_we |=> $stable(st_q.sel));

    assert_regs_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_we |=> ($stable(ae_q) && $stable(af_q)));

    assert_empty_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && st_q.sel == SEL_EMPTY) |=> ($stable(af_q) && ae_q == $past(wdata)));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && st_q.sel == SEL_FULL) |=> ($stable(ae_q) && af_q == $past(wdata)));

endmodule

// File: rtl/thr_rd_port.sv
module thr_rd_port
    import thr_pkg::*;
#(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_re,
    input  logic [OFS_W-1:0]  ae,
    input  logic [OFS_W-1:0]  af,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned PAD_W = DATA_W - OFS_W;

    typedef struct packed {
        ofs_sel_e          sel;
        logic [DATA_W-1:0] q;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [OFS_W-1:0] pick;

    always_comb begin
        pick = (st_q.sel == SEL_EMPTY) ? ae : af;
        st_d = st_q;
        if (prog_re) begin
            st_d.q   = {{PAD_W{1'b0}}, pick};
            st_d.sel = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= SEL_EMPTY;
            st_q.q   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.q;

    assert_rsel_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_re |=> (st_q.sel != $past(st_q.sel)));

    assert_rsel_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_re |=> $stable(st_q.sel));

    assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_re |=> $stable(dout));

    assert_dout_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_re |=> (dout[DATA_W-1:OFS_W] == '0));

endmodule

// File: rtl/thr_prog_seq.sv
module thr_prog_seq
    import thr_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 18
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [OFS_W-1:0]  wr_din,
    output logic [DATA_W-1:0] rd_dout,
    output logic [OFS_W-1:0]  ae_thresh,
    output logic [OFS_W-1:0]  af_thresh,
    output logic              buf_wr,
    output logic              buf_rd
);

    localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(depth_default(DEPTH));

    logic prog_we;
    logic prog_re;

    thr_steer i_steer (
        .load_n  (load_n),
        .wr_en_n (wr_en_n),
        .rd_en_n (rd_en_n),
        .prog_we (prog_we),
        .prog_re (prog_re),
        .buf_we  (buf_wr),
        .buf_re  (buf_rd)
    );

    thr_wr_bank #(
        .OFS_W   (OFS_W),
        .RST_OFS (RST_OFS)
    ) i_wr_bank (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .prog_we (prog_we),
        .wdata   (wr_din),
        .ae_q    (ae_thresh),
        .af_q    (af_thresh)
    );

    thr_rd_port #(
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W)
    ) i_rd_port (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .prog_re (prog_re),
        .ae      (ae_thresh),
        .af      (af_thresh),
        .dout    (rd_dout)
    );

    assert_buf_wr_keeps_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        buf_wr |=> ($stable(ae_thresh) && $stable(af_thresh)));

    assert_buf_rd_keeps_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        buf_rd |=> $stable(rd_dout));

endmodule

// File: tb/test_thr_prog_seq.sv
module test_thr_prog_seq;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        load_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic [11:0] wr_din = '0;
    logic [17:0] rd_dout;
    logic [11:0] ae_thresh, af_thresh;
    logic        buf_wr, buf_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural model state
    int unsigned m_ae = 12'h07F, m_af = 12'h07F, m_dout = 0;
    int          m_wsel = 0, m_rsel = 0;

    thr_prog_seq i_thr_prog_seq (
        .wr_clk    (wr_clk),
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .rd_en_n   (rd_en_n),
        .wr_din    (wr_din),
        .rd_dout   (rd_dout),
        .ae_thresh (ae_thresh),
        .af_thresh (af_thresh),
        .buf_wr    (buf_wr),
        .buf_rd    (buf_rd)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic check(string req, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // write-domain model and per-cycle compare
    always @(posedge wr_clk) begin
        if (!rst_n) begin
            m_ae = 12'h07F; m_af = 12'h07F; m_wsel = 0;
        end else if (!load_n && !wr_en_n) begin
            if (m_wsel == 0) m_ae = wr_din; else m_af = wr_din;
            m_wsel = 1 - m_wsel;
        end
        #2;
        check("R2", "ae_thresh", ae_thresh, m_ae);
        check("R2", "af_thresh", af_thresh, m_af);
        check("R3", "buf_wr", buf_wr, (load_n && !wr_en_n) ? 1 : 0);
    end

    // read-domain model and per-cycle compare
    always @(posedge rd_clk) begin
        if (!rst_n) begin
            m_dout = 0; m_rsel = 0;
        end else if (!load_n && !rd_en_n) begin
            m_dout = (m_rsel == 0) ? m_ae : m_af;
            m_rsel = 1 - m_rsel;
        end
        #1;
        check("R6", "rd_dout", rd_dout, m_dout);
        check("R7", "buf_rd", buf_rd, (load_n && !rd_en_n) ? 1 : 0);
    end

    task automatic wr_op(bit ld, bit we, logic [11:0] d);
        @(negedge wr_clk);
        load_n = ld; wr_en_n = we; wr_din = d; rd_en_n = 1'b1;
        @(posedge wr_clk);
        #2;
    endtask

    task automatic rd_op(bit ld, bit re);
        @(negedge rd_clk);
        load_n = ld; rd_en_n = re; wr_en_n = 1'b1;
        @(posedge rd_clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        #25;
        check("R1", "reset ae", ae_thresh, 12'h07F);
        check("R1", "reset af", af_thresh, 12'h07F);
        check("R1", "reset dout", rd_dout, 0);
        #6 rst_n = 1'b1;

        wr_op(0, 0, 12'h123);
        check("R2", "first write to empty", ae_thresh, 12'h123);
        check("R2", "full untouched", af_thresh, 12'h07F);
        wr_op(1, 0, 12'hABC);
        check("R3", "ae after buffer write", ae_thresh, 12'h123);
        check("R3", "af after buffer write", af_thresh, 12'h07F);
        check("R3", "buf_wr strobe", buf_wr, 1);
        wr_op(0, 1, 12'hDEF);
        check("R4", "ae with enable high", ae_thresh, 12'h123);
        check("R4", "af with enable high", af_thresh, 12'h07F);
        check("R4", "buf_wr low", buf_wr, 0);
        wr_op(0, 0, 12'h456);
        check("R5", "resumed write hits full", af_thresh, 12'h456);
        check("R5", "empty kept", ae_thresh, 12'h123);
        wr_op(0, 0, 12'h789);
        check("R2", "third write wraps to empty", ae_thresh, 12'h789);
        wr_op(1, 1, 12'h000);

        rd_op(0, 0);
        check("R6", "readback empty", rd_dout, 18'h00789);
        rd_op(0, 0);
        check("R6", "readback full", rd_dout, 18'h00456);
        rd_op(0, 1);
        check("R7", "hold on enable high", rd_dout, 18'h00456);
        rd_op(1, 0);
        check("R7", "hold on load high", rd_dout, 18'h00456);
        check("R7", "buf_rd strobe", buf_rd, 1);
        rd_op(0, 0);
        check("R6", "readback wraps", rd_dout, 18'h00789);

        // both pointers now on the full position: reset mid-sequence
        @(negedge wr_clk);
        load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        #1 rst_n = 1'b0;
        #3;
        check("R1", "mid reset ae", ae_thresh, 12'h07F);
        check("R1", "mid reset dout", rd_dout, 0);
        #20 rst_n = 1'b1;
        wr_op(0, 0, 12'h0AA);
        check("R8", "write after reset hits empty", ae_thresh, 12'h0AA);
        check("R8", "full back to default", af_thresh, 12'h07F);
        rd_op(0, 0);
        check("R8", "read after reset gives empty", rd_dout, 18'h000AA);

        for (int i = 0; i < 600; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            if (r[0])
                wr_op(r[1], r[2], 12'($urandom));
            else
                rd_op(r[1], r[2]);
        end

        @(negedge wr_clk);
        load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        repeat (3) @(posedge wr_clk);
        #4;
        finish_run();
    end

endmodule